// File: doc/BRIEF.md
# Banked Index/Data Configuration Register File

This block is a host-reachable configuration space behind two bus addresses. One address holds an index pointer. The other address is a data window onto whatever location the pointer selects. Index values below 30h reach unbanked state: a bank-select register and a sixteen-byte global region. From 30h upward, an access is resolved in two dimensions. The index picks the location, and the bank-select register picks one of eleven per-device banks.

Each bank holds the following:
- a device-enable control bit;
- eight standard configuration bytes, two of which describe DMA use;
- fifteen vendor-defined bytes.

Each bank's enable, configuration and vendor bytes leave the block as flat vectors, so the device logic can use them directly. Locations that are not implemented accept writes and discard them. They read back 00h, except at the two DMA offsets, which read back 04h to signal that no DMA channel is assigned. The registers can be used from the first cycle after reset.

Top module: `cfg_regs`

## Requirements
- R1: A write with addr_i=0 loads the index register. A read with addr_i=0 returns its last written value. It resets to 00h.
- R2: A data-port access (addr_i=1) with the index at 07h reaches the bank-select register. The register resets to 00h and keeps any written value unchanged, including values above 0Ah.
- R3: Data-port accesses with the index at 20h–2Fh reach sixteen global bytes that are the same for every bank-select value. Byte n appears on glb_cfg_o[n*8 +: 8].
- R4: Data-port accesses with the index at 60h–63h, 70h–71h or 74h–75h reach standard byte slots 0–7 of bank b, where b is the current bank-select value (0 to 10). The slot order is 60h, 61h, 62h, 63h, 70h, 71h, 74h, 75h. A write changes only bank b. Slot s of bank b appears on bank_cfg_o[b*64 + s*8 +: 8].
- R5: In each bank, index 30h is the control register. Only bit 0, the device enable, is stored. The other bits read as 0. Bit 0 of bank b drives bank_en_o[b].
- R6: Indexes F0h–FEh reach vendor byte k = index−F0h of the selected bank. Byte k of bank b appears on bank_vnd_o[b*120 + k*8 +: 8].
- R7: A data-port write to an unimplemented index has no effect on any output or register. A read of such an index returns 00h.
- R8: While the bank-select value is above 0Ah, every data-port access with the index at 30h or above is treated as unimplemented. Writes are ignored. Reads return 04h at indexes 74h and 75h and 00h elsewhere.
- R9: On reset, every bank's enable is 0, every global, standard and vendor byte is 00h, and standard slots 6 and 7 (indexes 74h and 75h) are 04h.
- R10: A write takes effect on the clock edge and can be read in the next cycle, including the first cycle after reset is released. Read data is combinational and is 00h while re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 1 | Port select: 0 index, 1 data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| bank_en_o | output | 11 | Per-bank device enable |
| bank_cfg_o | output | 704 | Standard configuration bytes, 8 per bank |
| bank_vnd_o | output | 1320 | Vendor bytes, 15 per bank |
| glb_cfg_o | output | 128 | Global configuration bytes |

## Verification
On every cycle, the assertions check the following:
- an idle read port returns zero;
- the index and bank-select registers read back the value written one cycle earlier;
- the enable, configuration and vendor outputs hold still unless a data-port write occurred;
- banked writes never disturb the global bytes;
- with an out-of-range bank select, banked writes change nothing and banked reads return the 00h/04h defaults.

Only the bench scenarios can show where each byte lands. They show that each byte reaches its own slot in the selected bank, that the other banks are left untouched, that writes to unimplemented indexes below 30h are ignored, and what the reset image looks like after a reset applied mid-run.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned N_STD = 8;
  localparam int unsigned N_VND = 15;
  localparam int unsigned N_GLB = 16;
  localparam int unsigned SW    = 4;

  localparam logic [DW-1:0] IDX_LDN  = 8'h07;
  localparam logic [DW-1:0] IDX_CTRL = 8'h30;
  localparam logic [DW-1:0] NO_DMA   = 8'h04;

  typedef enum logic [2:0] {K_NONE, K_LDN, K_GLB, K_CTRL, K_STD, K_VND} kind_e;

  typedef struct packed {
    kind_e         kind;
    logic [SW-1:0] slot;
  } loc_t;

  function automatic loc_t decode(input logic [DW-1:0] idx);
    loc_t l;
    l.kind = K_NONE;
    l.slot = '0;
    if (idx == IDX_LDN) l.kind = K_LDN;
    else if (idx[7:4] == 4'h2) begin
      l.kind = K_GLB;
      l.slot = idx[3:0];
    end else if (idx == IDX_CTRL) l.kind = K_CTRL;
    else if (idx[7:2] == 6'b0110_00) begin
      l.kind = K_STD;
      l.slot = {2'b00, idx[1:0]};
    end else if (idx[7:1] == 7'b0111_000) begin
      l.kind = K_STD;
      l.slot = {3'b010, idx[0]};
    end else if (idx[7:1] == 7'b0111_010) begin
      l.kind = K_STD;
      l.slot = {3'b011, idx[0]};
    end else if (idx[7:4] == 4'hF && idx[3:0] != 4'hF) begin
      l.kind = K_VND;
      l.slot = idx[3:0];
    end
    return l;
  endfunction

  function automatic logic is_banked(input kind_e k);
    return (k == K_CTRL) || (k == K_STD) || (k == K_VND);
  endfunction

  function automatic logic is_dma(input logic [DW-1:0] idx);
    return (idx == 8'h74) || (idx == 8'h75);
  endfunction
endpackage

// File: rtl/cfg_ptr.sv
module cfg_ptr
  import cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic          ldn_we_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] idx_o,
  output logic [DW-1:0] ldn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
      ldn_o <= '0;
    end else begin
      if (idx_we_i) idx_o <= wd_i;
      if (ldn_we_i) ldn_o <= wd_i;
    end
  end
endmodule

// File: rtl/cfg_global.sv
module cfg_global
  import cfg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SW-1:0]       slot_i,
  input  logic [DW-1:0]       wd_i,
  output logic [DW-1:0]       rd_o,
  output logic [N_GLB*DW-1:0] cfg_o
);
  logic [DW-1:0] q [N_GLB];

  for (genvar g = 0; g < N_GLB; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q[g] <= '0;
      else if (we_i && slot_i == SW'(g))  q[g] <= wd_i;
    end
    assign cfg_o[g*DW +: DW] = q[g];
  end

  assign rd_o = q[slot_i];
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  loc_t                loc_i,
  input  logic [DW-1:0]       wd_i,
  output logic [DW-1:0]       rd_o,
  output logic                en_o,
  output logic [N_STD*DW-1:0] std_o,
  output logic [N_VND*DW-1:0] vnd_o
);
  logic [DW-1:0] std_q [N_STD];
  logic [DW-1:0] vnd_q [N_VND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           en_o <= 1'b0;
    else if (we_i && loc_i.kind == K_CTRL) en_o <= wd_i[0];
  end

  for (genvar s = 0; s < N_STD; s++) begin : g_std
    // upper two slots are the DMA bytes: reset to "no channel"
    localparam logic [DW-1:0] RST = (s >= N_STD - 2) ? NO_DMA : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) std_q[s] <= RST;
      else if (we_i && loc_i.kind == K_STD && loc_i.slot == SW'(s)) std_q[s] <= wd_i;
    end
    assign std_o[s*DW +: DW] = std_q[s];
  end

  for (genvar v = 0; v < N_VND; v++) begin : g_vnd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vnd_q[v] <= '0;
      else if (we_i && loc_i.kind == K_VND && loc_i.slot == SW'(v)) vnd_q[v] <= wd_i;
    end
    assign vnd_o[v*DW +: DW] = vnd_q[v];
  end

  always_comb begin
    unique case (loc_i.kind)
      K_CTRL:  rd_o = {{(DW-1){1'b0}}, en_o};
      K_STD:   rd_o = std_q[loc_i.slot];
      K_VND:   rd_o = vnd_q[loc_i.slot];
      default: rd_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_pkg::*;
#(
  parameter int unsigned N_BANK = 11
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       addr_i,
  input  logic                       we_i,
  input  logic                       re_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  output logic [N_BANK-1:0]          bank_en_o,
  output logic [N_BANK*N_STD*DW-1:0] bank_cfg_o,
  output logic [N_BANK*N_VND*DW-1:0] bank_vnd_o,
  output logic [N_GLB*DW-1:0]        glb_cfg_o
);
  logic [DW-1:0] idx_q, ldn_q, glb_rd, dflt, bank_rd_sel, rd_val;
  logic [DW-1:0] bank_rd [N_BANK];
  logic          dwr;
  loc_t          loc;

  assign loc = decode(idx_q);
  assign dwr = we_i && addr_i;

  cfg_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_we_i (we_i && !addr_i),
    .ldn_we_i (dwr && loc.kind == K_LDN),
    .wd_i     (wdata_i),
    .idx_o    (idx_q),
    .ldn_o    (ldn_q)
  );

  cfg_global u_glb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (dwr && loc.kind == K_GLB),
    .slot_i (loc.slot),
    .wd_i   (wdata_i),
    .rd_o   (glb_rd),
    .cfg_o  (glb_cfg_o)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    cfg_bank u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (dwr && is_banked(loc.kind) && ldn_q == DW'(b)),
      .loc_i  (loc),
      .wd_i   (wdata_i),
      .rd_o   (bank_rd[b]),
      .en_o   (bank_en_o[b]),
      .std_o  (bank_cfg_o[b*N_STD*DW +: N_STD*DW]),
      .vnd_o  (bank_vnd_o[b*N_VND*DW +: N_VND*DW])
    );
  end

  assign dflt = is_dma(idx_q) ? NO_DMA : '0;

  // out-of-range bank select falls through to the default value
  always_comb begin
    bank_rd_sel = dflt;
    for (int b = 0; b < N_BANK; b++)
      if (ldn_q == DW'(b)) bank_rd_sel = bank_rd[b];
  end

  always_comb begin
    unique case (loc.kind)
      K_LDN:                rd_val = ldn_q;
      K_GLB:                rd_val = glb_rd;
      K_CTRL, K_STD, K_VND: rd_val = bank_rd_sel;
      default:              rd_val = dflt;
    endcase
  end

  assign rdata_o = !re_i ? '0 : (addr_i ? rd_val : idx_q);
endmodule

// File: rtl/cfg_regs_chk.sv
module cfg_regs_chk
  import cfg_pkg::*;
#(
  parameter int unsigned N_BANK = 11
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       addr_i,
  input logic                       we_i,
  input logic                       re_i,
  input logic [DW-1:0]              wdata_i,
  input logic [DW-1:0]              rdata_o,
  input logic [N_BANK-1:0]          bank_en_o,
  input logic [N_BANK*N_STD*DW-1:0] bank_cfg_o,
  input logic [N_BANK*N_VND*DW-1:0] bank_vnd_o,
  input logic [N_GLB*DW-1:0]        glb_cfg_o,
  input logic [DW-1:0]              idx_q,
  input logic [DW-1:0]              ldn_q
);
  logic oob, hi;
  assign oob = ldn_q >= DW'(N_BANK);
  assign hi  = idx_q >= 8'h30;

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0);

  a_r1_index_rb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !addr_i && $past(we_i && !addr_i)) |-> rdata_o == $past(wdata_i));

  a_r2_ldn_rb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i && idx_q == 8'h07 && $past(we_i && addr_i) && $past(idx_q) == 8'h07)
      |-> rdata_o == $past(wdata_i));

  a_r5_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && addr_i) |-> $stable(bank_en_o));

  a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && addr_i) |-> ($stable(bank_cfg_o) && $stable(bank_vnd_o) && $stable(glb_cfg_o)));

  a_r3_glb_unbanked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && hi) |=> $stable(glb_cfg_o));

  a_r8_oob_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oob && we_i && addr_i && hi)
      |=> ($stable(bank_cfg_o) && $stable(bank_vnd_o) && $stable(bank_en_o)));

  a_r8_oob_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oob && re_i && addr_i && hi)
      |-> rdata_o == (((idx_q == 8'h74) || (idx_q == 8'h75)) ? 8'h04 : 8'h00));
endmodule

bind cfg_regs cfg_regs_chk #(.N_BANK(N_BANK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .re_i       (re_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .bank_en_o  (bank_en_o),
  .bank_cfg_o (bank_cfg_o),
  .bank_vnd_o (bank_vnd_o),
  .glb_cfg_o  (glb_cfg_o),
  .idx_q      (idx_q),
  .ldn_q      (ldn_q)
);

// File: tb/sim_cfg_regs.sv
`timescale 1ns/1ps
module sim_cfg_regs;
  localparam int NB = 11;
  localparam int CW = NB*64;
  localparam int VW = NB*120;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          addr_i = 1'b0, we_i = 1'b0, re_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic [NB-1:0] bank_en_o;
  logic [CW-1:0] bank_cfg_o;
  logic [VW-1:0] bank_vnd_o;
  logic [127:0]  glb_cfg_o;

  int errs = 0, checks = 0;

  always #2 clk_i = ~clk_i;

  cfg_regs #(.N_BANK(NB)) u0 (
    .clk_i, .rst_ni, .addr_i, .we_i, .re_i, .wdata_i, .rdata_o,
    .bank_en_o, .bank_cfg_o, .bank_vnd_o, .glb_cfg_o
  );

  typedef struct packed {
    logic       wr;
    logic       port;
    logic [7:0] d;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,8'h07,4'd2}, '{1'b1,1'b1,8'h03,4'd2}, '{1'b0,1'b1,8'h03,4'd2},  // R2 select bank 3
    '{1'b1,1'b0,8'h60,4'd4}, '{1'b1,1'b1,8'hA5,4'd4}, '{1'b0,1'b1,8'hA5,4'd4},  // R4
    '{1'b1,1'b0,8'h07,4'd4}, '{1'b1,1'b1,8'h05,4'd4}, '{1'b1,1'b0,8'h60,4'd4},
    '{1'b0,1'b1,8'h00,4'd4},                                                    // R4 other bank clean
    '{1'b1,1'b0,8'h20,4'd3}, '{1'b1,1'b1,8'h5C,4'd3}, '{1'b1,1'b0,8'h07,4'd3},
    '{1'b1,1'b1,8'h02,4'd3}, '{1'b1,1'b0,8'h20,4'd3}, '{1'b0,1'b1,8'h5C,4'd3},  // R3 shared
    '{1'b1,1'b0,8'h30,4'd5}, '{1'b1,1'b1,8'hFF,4'd5}, '{1'b0,1'b1,8'h01,4'd5},  // R5
    '{1'b1,1'b0,8'hFE,4'd6}, '{1'b1,1'b1,8'h3C,4'd6}, '{1'b0,1'b1,8'h3C,4'd6},  // R6
    '{1'b1,1'b0,8'h74,4'd9}, '{1'b0,1'b1,8'h04,4'd9},                           // R9
    '{1'b1,1'b0,8'h50,4'd7}, '{1'b1,1'b1,8'h77,4'd7}, '{1'b0,1'b1,8'h00,4'd7},  // R7
    '{1'b1,1'b0,8'h1F,4'd7}, '{1'b1,1'b1,8'h66,4'd7}, '{1'b0,1'b1,8'h00,4'd7},
    '{1'b1,1'b0,8'h64,4'd7}, '{1'b0,1'b1,8'h00,4'd7},
    '{1'b1,1'b0,8'h07,4'd2}, '{1'b1,1'b1,8'h0B,4'd2}, '{1'b0,1'b1,8'h0B,4'd2},  // R2 out-of-range kept
    '{1'b1,1'b0,8'h60,4'd8}, '{1'b1,1'b1,8'h99,4'd8}, '{1'b0,1'b1,8'h00,4'd8},  // R8
    '{1'b1,1'b0,8'h75,4'd8}, '{1'b0,1'b1,8'h04,4'd8},
    '{1'b1,1'b0,8'h20,4'd3}, '{1'b0,1'b1,8'h5C,4'd3},
    '{1'b1,1'b0,8'h07,4'd8}, '{1'b1,1'b1,8'h03,4'd8}, '{1'b1,1'b0,8'h60,4'd8},
    '{1'b0,1'b1,8'hA5,4'd8},                                                    // R8 no effect
    '{1'b0,1'b0,8'h60,4'd1}                                                     // R1 index readback
  };

  task automatic chk(input string req, input logic [1319:0] act, input logic [1319:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = port; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic port, input logic [7:0] exp, input int req);
    @(negedge clk_i);
    addr_i = port; re_i = 1'b1;
    #1;
    chk($sformatf("R%0d read", req), 1320'(rdata_o), 1320'(exp));
    re_i = 1'b0;
  endtask

  function automatic logic [CW-1:0] cfg_rst();
    logic [CW-1:0] v = '0;
    for (int b = 0; b < NB; b++) begin
      v[b*64+48 +: 8] = 8'h04;
      v[b*64+56 +: 8] = 8'h04;
    end
    return v;
  endfunction

  initial begin
    #(4*200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [CW-1:0] c0;
    logic [VW-1:0] v0;
    logic [127:0]  g0;
    logic [NB-1:0] e0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: usable in the first cycle after reset
    wr(1'b0, 8'h63);
    rd(1'b0, 8'h63, 1);
    wr(1'b0, 8'h07);
    rd(1'b1, 8'h00, 2);              // R2 reset value
    chk("R9 en", 1320'(bank_en_o), '0);
    chk("R9 cfg", 1320'(bank_cfg_o), 1320'(cfg_rst()));
    chk("R9 vnd", 1320'(bank_vnd_o), '0);
    chk("R9 glb", 1320'(glb_cfg_o), '0);
    wr(1'b0, 8'h63);
    wr(1'b1, 8'h5A);
    rd(1'b1, 8'h5A, 10);             // R10 next-cycle visibility
    #1 chk("R10 idle rdata", 1320'(rdata_o), '0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].port, VEC[i].d);
      else rd(VEC[i].port, VEC[i].d, int'(VEC[i].req));
    end

    @(negedge clk_i);
    chk("R4 flat bank3 slot0", 1320'(bank_cfg_o[3*64 +: 8]), 1320'(8'hA5));
    chk("R4 flat bank0 slot3", 1320'(bank_cfg_o[0*64+24 +: 8]), 1320'(8'h5A));
    chk("R5 enables", 1320'(bank_en_o), 1320'(11'b000_0000_0100));
    chk("R6 flat vendor", 1320'(bank_vnd_o[2*120+14*8 +: 8]), 1320'(8'h3C));
    chk("R3 flat global", 1320'(glb_cfg_o[0 +: 8]), 1320'(8'h5C));

    // R7: unimplemented writes leave every output unchanged
    c0 = bank_cfg_o; v0 = bank_vnd_o; g0 = glb_cfg_o; e0 = bank_en_o;
    wr(1'b0, 8'h50); wr(1'b1, 8'h11);
    wr(1'b0, 8'h00); wr(1'b1, 8'h22);
    wr(1'b0, 8'hFF); wr(1'b1, 8'h33);
    @(negedge clk_i);
    chk("R7 cfg unchanged", 1320'(bank_cfg_o), 1320'(c0));
    chk("R7 vnd unchanged", 1320'(bank_vnd_o), 1320'(v0));
    chk("R7 glb unchanged", 1320'(glb_cfg_o), 1320'(g0));
    chk("R7 en unchanged", 1320'(bank_en_o), 1320'(e0));

    // R8: bank select 0Ch, banked writes dropped
    wr(1'b0, 8'h07); wr(1'b1, 8'h0C);
    wr(1'b0, 8'h30); wr(1'b1, 8'h01);
    wr(1'b0, 8'hF0); wr(1'b1, 8'hEE);
    wr(1'b0, 8'h74); wr(1'b1, 8'h00);
    rd(1'b1, 8'h04, 8);
    @(negedge clk_i);
    chk("R8 cfg unchanged", 1320'(bank_cfg_o), 1320'(c0));
    chk("R8 vnd unchanged", 1320'(bank_vnd_o), 1320'(v0));
    chk("R8 en unchanged", 1320'(bank_en_o), 1320'(e0));

    // R9: reset applied mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 chk("R9 async en", 1320'(bank_en_o), '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R9 cfg after reset", 1320'(bank_cfg_o), 1320'(cfg_rst()));
    chk("R9 vnd after reset", 1320'(bank_vnd_o), '0);
    chk("R9 glb after reset", 1320'(glb_cfg_o), '0);
    rd(1'b0, 8'h00, 1);              // R1 index reset

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule